// File: doc/BRIEF.md
# DMA Channel Status and Burst Request Registers

This block holds three small status and request words for a multi-channel DMA controller and presents them on a simple synchronous register bus. One word latches per-channel error events as raw, unmasked error interrupt requests. A second word shows which channels are enabled; each bit is set from the channel's configuration and drops by itself when that channel's transfer completes. A third word lets software raise a burst request for any of sixteen request sources.

Software request bits are write-one-to-set. Written zeros leave them unchanged, and each bit clears itself when its source reports a finished transaction. For each source, the burst request sent to the channel arbiter is the OR of the peripheral request line and the stored software bit. A read of the request word returns that same combined view.

Top module: `dma_chan_status_regs`

## Requirements
- R1: After reset all three words read as zero, `breq_out` is zero and `bus_rdata` is zero.
- R2: A 1 on `err_set[i]` sets error bit i, which stays set until a 1 on `err_clr[i]`. If both arrive in the same cycle, the bit ends up set.
- R3: A 1 on `ch_en_set[i]` sets enabled bit i, and a 1 on `ch_done[i]` clears it. If both arrive in the same cycle, the bit ends up set.
- R4: A write at offset 0x8 sets every software request bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value, and `bus_wdata[31:16]` is ignored.
- R5: A 1 on `src_done[j]` clears software request bit j. A write of 1 to bit j in the same cycle wins, so the bit ends up set.
- R6: `breq_out[j]` equals `periph_breq[j]` OR software request bit j, with no added delay.
- R7: A read at offset 0x8 returns the combined requests (peripheral OR software) in bits [15:0] and zero in bits [31:16].
- R8: Writes at offset 0x0 (error word) and 0x4 (enabled word) change neither word.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd`. It is zero for unused offsets and in every cycle that follows no read strobe. Bits above the word width read as zero: error word in [7:0] at 0x0, enabled word in [7:0] at 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| err_set | input | 8 | Per-channel error event pulses |
| err_clr | input | 8 | Per-channel error clear pulses |
| ch_en_set | input | 8 | Per-channel enable pulses |
| ch_done | input | 8 | Per-channel transfer-complete pulses |
| periph_breq | input | 16 | Peripheral burst request lines |
| src_done | input | 16 | Per-source transaction-complete pulses |
| breq_out | output | 16 | Combined burst requests to the arbiter |

## Verification
The embedded assertions check the following on every cycle:
- error bits change only in cycles that carry a set or clear pulse;
- an error or enable set pulse always takes effect;
- a completion pulse with no competing set clears its enable bit;
- software request bits rise only where a 1 was written at offset 0x8;
- `bus_rdata` is zero after any cycle without a read strobe.

The directed scenarios cover the rest:
- exact word contents, including same-cycle set/clear priority;
- written zeros having no effect;
- writes to the read-only words being ignored;
- the combined read value when peripheral lines are active;
- zero data from unused offsets.

// File: rtl/dma_chan_status_regs.sv
module dma_chan_status_regs #(
  parameter int NCH = 8,
  parameter int NSRC = 16,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NCH-1:0]  err_set,
  input  logic [NCH-1:0]  err_clr,
  input  logic [NCH-1:0]  ch_en_set,
  input  logic [NCH-1:0]  ch_done,
  input  logic [NSRC-1:0] periph_breq,
  input  logic [NSRC-1:0] src_done,
  output logic [NSRC-1:0] breq_out
);

  localparam logic [AW-1:0] OFF_ERR  = AW'(4'h0);
  localparam logic [AW-1:0] OFF_EN   = AW'(4'h4);
  localparam logic [AW-1:0] OFF_BREQ = AW'(4'h8);

  logic [NCH-1:0]  err_q, en_q;
  logic [NSRC-1:0] sw_q, sw_wr;
  logic [DW-1:0]   rd_mux;

  assign sw_wr    = (bus_wr && bus_addr == OFF_BREQ) ? bus_wdata[NSRC-1:0] : '0;
  assign breq_out = periph_breq | sw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
      en_q  <= '0;
      sw_q  <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set;
      en_q  <= (en_q & ~ch_done) | ch_en_set;
      sw_q  <= (sw_q & ~src_done) | sw_wr;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFF_ERR:  rd_mux[NCH-1:0]  = err_q;
      OFF_EN:   rd_mux[NCH-1:0]  = en_q;
      OFF_BREQ: rd_mux[NSRC-1:0] = breq_out;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end

  AST_ERR_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q ^ $past(err_q)) & ~$past(err_set | err_clr)) == '0); // R2
  AST_ERR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    |err_set |=> (err_q & $past(err_set)) == $past(err_set)); // R2
  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    |ch_en_set |=> (en_q & $past(ch_en_set)) == $past(ch_en_set)); // R3
  AST_EN_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    |(ch_done & ~ch_en_set) |=> (en_q & $past(ch_done & ~ch_en_set)) == '0); // R3
  AST_SW_RISE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q & ~$past(sw_q) & ~(($past(bus_wr) && $past(bus_addr) == OFF_BREQ)
      ? $past(bus_wdata[NSRC-1:0]) : '0)) == '0); // R4
  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_BREQ) |=>
      (sw_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])); // R5
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> bus_rdata == '0); // R9

endmodule

// File: tb/dma_chan_status_regs_tb.sv
module dma_chan_status_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] err_set = 0, err_clr = 0, ch_en_set = 0, ch_done = 0;
  logic [15:0] periph_breq = 0, src_done = 0, breq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_chan_status_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_set(err_set), .err_clr(err_clr),
    .ch_en_set(ch_en_set), .ch_done(ch_done), .periph_breq(periph_breq),
    .src_done(src_done), .breq_out(breq_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R1 err", d, 0);
    rd(4'h4, d); chk("R1 en", d, 0);
    rd(4'h8, d); chk("R1 breq", d, 0);
    chk("R1 breq_out", {16'h0, breq_out}, 0);
  endtask

  task automatic t_err;
    logic [31:0] d;
    @(negedge clk); err_set = 8'h05;
    @(negedge clk); err_set = 0;
    rd(4'h0, d); chk("R2 set", d, 32'h05);
    @(negedge clk); err_set = 8'h80; err_clr = 8'h81;
    @(negedge clk); err_set = 0; err_clr = 0;
    rd(4'h0, d); chk("R2 clr and set wins", d, 32'h84);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R8 err write ignored", d, 32'h84);
  endtask

  task automatic t_en;
    logic [31:0] d;
    @(negedge clk); ch_en_set = 8'h0F;
    @(negedge clk); ch_en_set = 0;
    rd(4'h4, d); chk("R3 set", d, 32'h0F);
    @(negedge clk); ch_done = 8'h03;
    @(negedge clk); ch_done = 0;
    rd(4'h4, d); chk("R3 done clears", d, 32'h0C);
    wr(4'h4, 32'h0000_00F3);
    rd(4'h4, d); chk("R8 en write ignored", d, 32'h0C);
    @(negedge clk); ch_en_set = 8'h10; ch_done = 8'h10;
    @(negedge clk); ch_en_set = 0; ch_done = 0;
    rd(4'h4, d); chk("R3 set wins", d, 32'h1C);
  endtask

  task automatic t_sw;
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_00A5);
    rd(4'h8, d); chk("R4 write1 set", d, 32'h00A5);
    chk("R6 breq_out", {16'h0, breq_out}, 32'h00A5);
    wr(4'h8, 32'h0);
    rd(4'h8, d); chk("R4 zeros no effect", d, 32'h00A5);
    wr(4'h8, 32'h0100);
    rd(4'h8, d); chk("R4 add bit", d, 32'h01A5);
    @(negedge clk); src_done = 16'h0005;
    @(negedge clk); src_done = 0;
    rd(4'h8, d); chk("R5 done clears", d, 32'h01A0);
    @(negedge clk); bus_addr = 4'h8; bus_wdata = 32'h0080; bus_wr = 1; src_done = 16'h0080;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; src_done = 0;
    rd(4'h8, d); chk("R5 set wins", d, 32'h01A0);
  endtask

  task automatic t_periph;
    logic [31:0] d;
    @(negedge clk); periph_breq = 16'h8000;
    #1 chk("R6 combined", {16'h0, breq_out}, 32'h81A0);
    rd(4'h8, d); chk("R7 read union", d, 32'h81A0);
    periph_breq = 0;
    #1 chk("R6 periph drop", {16'h0, breq_out}, 32'h01A0);
    rd(4'hC, d); chk("R9 unused offset", d, 0);
    @(negedge clk); chk("R9 idle zero", bus_rdata, 0);
    @(negedge clk); bus_addr = 4'h0; bus_rd = 1;
    #2 chk("R9 not same cycle", bus_rdata, 0);
    @(negedge clk); bus_rd = 0; chk("R9 next cycle", bus_rdata, 32'h84);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_err; t_en; t_sw; t_periph;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule